// File: doc/BRIEF.md
# Byte Accumulator Arithmetic/Logic Unit

This block is the arithmetic and logic core of an 8-bit accumulator machine. Each operation takes the accumulator byte, a source byte, the auxiliary B byte and the carry flag. It returns a new accumulator, a new B byte, a new carry and a divide error flag. The operations cover binary arithmetic with carry and borrow, single-step increment and decrement, bitwise logic, four rotates, and an unsigned multiply and divide. The multiply and the divide spread their results over both the accumulator and B.

The datapath itself is combinational. The top module registers the four results on every rising clock edge, so a result appears one cycle after its operands are presented. Instruction decode, register-file access and memory are handled outside this block.

Top module: `acc_alu`

## Requirements
- R1: `op_i` selects the operation: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 complement, 6 clear, 7 AND, 8 OR, 9 XOR, 10 rotate right, 11 rotate left, 12 rotate right through carry, 13 rotate left through carry, 14 multiply, 15 divide. The registered outputs take the result at the first rising edge after the inputs are applied. Synchronous reset drives all outputs to 0.
- R2: Add returns (A + src) mod 256 and ignores `cy_i`. Add-with-carry returns (A + src + cy_i) mod 256. Both set the carry to the unsigned carry-out of bit 7.
- R3: Subtract-with-borrow always returns (A - src - cy_i) mod 256. It sets the carry when the true difference is negative and clears it otherwise.
- R4: Multiply forms the unsigned 16-bit product of A and B. The high byte goes to B, the low byte goes to A, and the carry is cleared. For example, 0x25 times 0x65 gives B=0x0E and A=0x99.
- R5: Divide with a nonzero B puts the unsigned quotient A/B into A and the remainder into B. It clears the carry and the error flag. For example, 25/10 gives A=2 and B=5.
- R6: Divide with B equal to zero returns A and B unchanged, clears the carry and sets `err_o`. Every other case leaves `err_o` at 0.
- R7: Increment and decrement change A by one, wrapping modulo 256, and return the carry unchanged.
- R8: Complement returns the inverse of every bit of A. Clear returns 0. AND, OR and XOR combine A with src bit by bit. All five return the carry unchanged.
- R9: Rotate right moves bit 0 of A into bit 7. Rotate left moves bit 7 of A into bit 0. Both return the carry unchanged.
- R10: Rotate right through carry moves the carry into bit 7 and bit 0 into the carry. Rotate left through carry moves the carry into bit 0 and bit 7 into the carry.
- R11: Every operation other than multiply and divide returns B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation select (codes in R1) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Auxiliary B operand (multiply, divide) |
| src_i | input | 8 | Source byte for two-operand operations |
| cy_i | input | 1 | Incoming carry flag |
| a_o | output | 8 | New accumulator, registered |
| b_o | output | 8 | New B byte, registered |
| cy_o | output | 1 | New carry flag, registered |
| err_o | output | 1 | Divide-by-zero flag, registered |

## Verification
All four outputs pass through a single register stage, so each result is due exactly one rising edge after its operands are driven. The bench applies the operands on a falling edge and reads the outputs on the next falling edge. Between those two reads there is exactly one rising edge, and the inputs are stable around it. The embedded properties use the same one-cycle relation: each compares the outputs with the value `$past` returns for the inputs one cycle earlier.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_CPL  = 4'd5,
        OP_CLR  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_ROR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_RORC = 4'd12,
        OP_ROLC = 4'd13,
        OP_MUL  = 4'd14,
        OP_DIV  = 4'd15
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] aux;
        logic              cy;
        logic              err;
    } alu_res_t;

    typedef enum logic [1:0] {
        UNIT_ARITH  = 2'd0,
        UNIT_LOGIC  = 2'd1,
        UNIT_MULDIV = 2'd2
    } unit_e;

    function automatic unit_e unit_of(op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC: unit_of = UNIT_ARITH;
            OP_MUL, OP_DIV:                           unit_of = UNIT_MULDIV;
            default:                                  unit_of = UNIT_LOGIC;
        endcase
    endfunction

    function automatic logic uses_aux(op_e op);
        uses_aux = (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] src_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int EW = W + 1;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] s_ext;
    logic [EW-1:0] c_ext;
    logic [EW-1:0] wide;

    assign a_ext = {1'b0, a_i};
    assign s_ext = {1'b0, src_i};
    assign c_ext = {{W{1'b0}}, cy_i};

    always_comb begin
        wide  = '0;
        res_o = a_i;
        cy_o  = cy_i;
        case (op_i)
            OP_ADD: begin
                wide  = a_ext + s_ext;
                res_o = wide[W-1:0];
                cy_o  = wide[W];
            end
            OP_ADDC: begin
                wide  = a_ext + s_ext + c_ext;
                res_o = wide[W-1:0];
                cy_o  = wide[W];
            end
            OP_SUBB: begin
                // the borrow shows up as bit W of the 9-bit difference
                wide  = a_ext - s_ext - c_ext;
                res_o = wide[W-1:0];
                cy_o  = wide[W];
            end
            OP_INC:  res_o = a_i + W'(1);
            OP_DEC:  res_o = a_i - W'(1);
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] src_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        case (op_i)
            OP_CPL:  res_o = ~a_i;
            OP_CLR:  res_o = '0;
            OP_AND:  res_o = a_i & src_i;
            OP_OR:   res_o = a_i | src_i;
            OP_XOR:  res_o = a_i ^ src_i;
            OP_ROR:  res_o = {a_i[0], a_i[W-1:1]};
            OP_ROL:  res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RORC: begin
                res_o = {cy_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_ROLC: begin
                res_o = {a_i[W-2:0], cy_i};
                cy_o  = a_i[W-1];
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         div_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] aux_o,
    output logic         err_o
);
    localparam int PW = 2 * W;
    localparam int SW = W + 1;

    logic [PW-1:0] prod;
    logic [W-1:0]  quot;
    logic [W-1:0]  rem_s [W+1];
    logic          div_zero;

    assign prod     = PW'(a_i) * PW'(b_i);
    assign div_zero = (b_i == '0);
    assign rem_s[0] = '0;

    // restoring division, one stage per quotient bit, MSB first
    for (genvar k = 0; k < W; k++) begin : g_stage
        logic [SW-1:0] shifted;
        logic [SW-1:0] diff;
        logic          fits;
        assign shifted       = {rem_s[k], a_i[W-1-k]};
        assign diff          = shifted - {1'b0, b_i};
        assign fits          = (shifted >= {1'b0, b_i});
        assign quot[W-1-k]   = fits;
        assign rem_s[k+1]    = fits ? diff[W-1:0] : shifted[W-1:0];
    end

    always_comb begin
        err_o = 1'b0;
        if (!div_i) begin
            acc_o = prod[W-1:0];
            aux_o = prod[PW-1:W];
        end else if (div_zero) begin
            acc_o = a_i;
            aux_o = b_i;
            err_o = 1'b1;
        end else begin
            acc_o = quot;
            aux_o = rem_s[W];
        end
    end

    // R5: a remainder is always below a nonzero divisor
    always_comb begin
        if (div_i && !div_zero) begin
            a_rem_lt_div_r5: assert (rem_s[W] < b_i);
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cy_i,
    output alu_res_t          res_o
);
    logic [DATA_W-1:0] ar_res;
    logic              ar_cy;
    logic [DATA_W-1:0] lg_res;
    logic              lg_cy;
    logic [DATA_W-1:0] md_acc;
    logic [DATA_W-1:0] md_aux;
    logic              md_err;

    acc_alu_arith #(.W(DATA_W)) arith_i (
        .op_i  (op_i),
        .a_i   (a_i),
        .src_i (src_i),
        .cy_i  (cy_i),
        .res_o (ar_res),
        .cy_o  (ar_cy)
    );

    acc_alu_logic #(.W(DATA_W)) logic_i (
        .op_i  (op_i),
        .a_i   (a_i),
        .src_i (src_i),
        .cy_i  (cy_i),
        .res_o (lg_res),
        .cy_o  (lg_cy)
    );

    acc_alu_muldiv #(.W(DATA_W)) muldiv_i (
        .div_i (op_i == OP_DIV),
        .a_i   (a_i),
        .b_i   (b_i),
        .acc_o (md_acc),
        .aux_o (md_aux),
        .err_o (md_err)
    );

    always_comb begin
        res_o.aux = b_i;
        res_o.err = 1'b0;
        case (unit_of(op_i))
            UNIT_ARITH: begin
                res_o.acc = ar_res;
                res_o.cy  = ar_cy;
            end
            UNIT_MULDIV: begin
                res_o.acc = md_acc;
                res_o.aux = md_aux;
                res_o.cy  = 1'b0;
                res_o.err = md_err;
            end
            default: begin
                res_o.acc = lg_res;
                res_o.cy  = lg_cy;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic              cy_o,
    output logic              err_o
);
    localparam int PW = 2 * DATA_W;

    op_e      op;
    alu_res_t res_d;
    alu_res_t res_q;

    assign op = op_e'(op_i);

    acc_alu_core core_i (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .src_i (src_i),
        .cy_i  (cy_i),
        .res_o (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign a_o   = res_q.acc;
    assign b_o   = res_q.aux;
    assign cy_o  = res_q.cy;
    assign err_o = res_q.err;

    p_mul_split_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MUL) |=> ({b_o, a_o} == (PW'($past(a_i)) * PW'($past(b_i)))) && !cy_o);

    p_div_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DIV && b_i == '0) |=>
            err_o && a_o == $past(a_i) && b_o == $past(b_i));

    p_err_only_div_r6: assert property (@(posedge clk) disable iff (rst)
        (op != OP_DIV) |=> !err_o);

    p_incdec_cy_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC || op == OP_DEC) |=> cy_o == $past(cy_i));

    p_aux_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !uses_aux(op) |=> b_o == $past(b_i));

    p_ror_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ROR) |=> a_o == {$past(a_i[0]), $past(a_i[DATA_W-1:1])});
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_i;
    logic [7:0] a_i, b_i, src_i;
    logic       cy_i;
    logic [7:0] a_o, b_o;
    logic       cy_o, err_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    acc_alu dut_i (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .src_i (src_i),
        .cy_i  (cy_i),
        .a_o   (a_o),
        .b_o   (b_o),
        .cy_o  (cy_o),
        .err_o (err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on a falling edge, result is read one falling edge later
    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] s, input logic c);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; src_i = s; cy_i = c;
        @(negedge clk);
    endtask

    task automatic expect_all(input string req, input logic [7:0] ea, input logic [7:0] eb,
                              input logic ec, input logic ee);
        chk({req, " acc"}, {24'd0, a_o}, {24'd0, ea});
        chk({req, " B"},   {24'd0, b_o}, {24'd0, eb});
        chk({req, " cy"},  {31'd0, cy_o}, {31'd0, ec});
        chk({req, " err"}, {31'd0, err_o}, {31'd0, ee});
    endtask

    task automatic t_reset_r1;
        rst = 1'b1;
        op_i = 4'd0; a_i = 8'hFF; b_i = 8'hFF; src_i = 8'hFF; cy_i = 1'b1;
        repeat (3) @(negedge clk);
        expect_all("R1 reset", 8'h00, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_add_r2;
        apply(4'd0, 8'hF0, 8'h11, 8'h20, 1'b1);
        expect_all("R2 add carry-out, cy_i ignored", 8'h10, 8'h11, 1'b1, 1'b0);
        apply(4'd0, 8'h10, 8'h11, 8'h05, 1'b1);
        expect_all("R2 add no carry", 8'h15, 8'h11, 1'b0, 1'b0);
        apply(4'd1, 8'h10, 8'h11, 8'h05, 1'b1);
        expect_all("R2 addc with cy", 8'h16, 8'h11, 1'b0, 1'b0);
        apply(4'd1, 8'hFF, 8'h11, 8'h00, 1'b1);
        expect_all("R2 addc wrap", 8'h00, 8'h11, 1'b1, 1'b0);
    endtask

    task automatic t_subb_r3;
        apply(4'd2, 8'h10, 8'h22, 8'h05, 1'b1);
        expect_all("R3 subb borrow-in", 8'h0A, 8'h22, 1'b0, 1'b0);
        apply(4'd2, 8'h05, 8'h22, 8'h10, 1'b0);
        expect_all("R3 subb borrow-out", 8'hF5, 8'h22, 1'b1, 1'b0);
        apply(4'd2, 8'h00, 8'h22, 8'h00, 1'b1);
        expect_all("R3 subb zero minus cy", 8'hFF, 8'h22, 1'b1, 1'b0);
    endtask

    task automatic t_mul_r4;
        apply(4'd14, 8'h25, 8'h65, 8'h00, 1'b1);
        expect_all("R4 mul example", 8'h99, 8'h0E, 1'b0, 1'b0);
        apply(4'd14, 8'hFF, 8'hFF, 8'h00, 1'b0);
        expect_all("R4 mul max", 8'h01, 8'hFE, 1'b0, 1'b0);
    endtask

    task automatic t_div_r5;
        apply(4'd15, 8'd25, 8'd10, 8'h00, 1'b1);
        expect_all("R5 div example", 8'd2, 8'd5, 1'b0, 1'b0);
        apply(4'd15, 8'd7, 8'd9, 8'h00, 1'b0);
        expect_all("R5 div small dividend", 8'd0, 8'd7, 1'b0, 1'b0);
        apply(4'd15, 8'hFF, 8'h01, 8'h00, 1'b0);
        expect_all("R5 div by one", 8'hFF, 8'h00, 1'b0, 1'b0);
        apply(4'd15, 8'd200, 8'd13, 8'h00, 1'b0);
        expect_all("R5 div general", 8'd15, 8'd5, 1'b0, 1'b0);
    endtask

    task automatic t_div0_r6;
        apply(4'd15, 8'h33, 8'h00, 8'h00, 1'b1);
        expect_all("R6 div by zero", 8'h33, 8'h00, 1'b0, 1'b1);
        apply(4'd0, 8'h01, 8'h00, 8'h01, 1'b0);
        expect_all("R6 err drops", 8'h02, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_incdec_r7;
        apply(4'd3, 8'hFF, 8'h44, 8'h00, 1'b1);
        expect_all("R7 inc wrap keeps cy", 8'h00, 8'h44, 1'b1, 1'b0);
        apply(4'd4, 8'h00, 8'h44, 8'h00, 1'b0);
        expect_all("R7 dec wrap keeps cy", 8'hFF, 8'h44, 1'b0, 1'b0);
    endtask

    task automatic t_logic_r8;
        apply(4'd5, 8'h55, 8'h01, 8'h00, 1'b1);
        expect_all("R8 cpl", 8'hAA, 8'h01, 1'b1, 1'b0);
        apply(4'd6, 8'h5A, 8'h01, 8'h00, 1'b0);
        expect_all("R8 clr", 8'h00, 8'h01, 1'b0, 1'b0);
        apply(4'd7, 8'hF0, 8'h01, 8'h3C, 1'b1);
        expect_all("R8 and", 8'h30, 8'h01, 1'b1, 1'b0);
        apply(4'd8, 8'hF0, 8'h01, 8'h0F, 1'b0);
        expect_all("R8 or", 8'hFF, 8'h01, 1'b0, 1'b0);
        apply(4'd9, 8'hFF, 8'h01, 8'h0F, 1'b1);
        expect_all("R8 xor", 8'hF0, 8'h01, 1'b1, 1'b0);
    endtask

    task automatic t_rot_r9;
        apply(4'd10, 8'h81, 8'h02, 8'h00, 1'b0);
        expect_all("R9 ror", 8'hC0, 8'h02, 1'b0, 1'b0);
        apply(4'd11, 8'h81, 8'h02, 8'h00, 1'b1);
        expect_all("R9 rol", 8'h03, 8'h02, 1'b1, 1'b0);
    endtask

    task automatic t_rotc_r10;
        apply(4'd12, 8'h01, 8'h03, 8'h00, 1'b0);
        expect_all("R10 rorc bit0 to cy", 8'h00, 8'h03, 1'b1, 1'b0);
        apply(4'd12, 8'h02, 8'h03, 8'h00, 1'b1);
        expect_all("R10 rorc cy to bit7", 8'h81, 8'h03, 1'b0, 1'b0);
        apply(4'd13, 8'h80, 8'h03, 8'h00, 1'b1);
        expect_all("R10 rolc", 8'h01, 8'h03, 1'b1, 1'b0);
        apply(4'd13, 8'h40, 8'h03, 8'h00, 1'b0);
        expect_all("R10 rolc no carry", 8'h80, 8'h03, 1'b0, 1'b0);
    endtask

    task automatic t_aux_hold_r11;
        for (int k = 0; k < 14; k++) begin
            apply(4'(k), 8'h5C, 8'h77, 8'h3A, 1'b1);
            chk("R11 B unchanged", {24'd0, b_o}, 32'h77);
        end
    endtask

    initial begin
        t_reset_r1();
        t_add_r2();
        t_subb_r3();
        t_mul_r4();
        t_div_r5();
        t_div0_r6();
        t_incdec_r7();
        t_logic_r8();
        t_rot_r9();
        t_rotc_r10();
        t_aux_hold_r11();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule